// File: doc/BRIEF.md
# Button Press Decade Counter

This block counts how many times a user pushes a button and presents the total as a single decimal digit, 0 to 9, in BCD. Everything runs on one internal clock. The button never clocks any flop. The raw contact level first goes through a debouncer. The clean level then passes through a short shift-register synchronizer. The leading edge of the synchronized level produces a count-enable pulse that is exactly one clock wide.

The debouncer is a four-state machine:
- `DB_LOW`: the level is settled low.
- `DB_RISING`: a high level is being timed.
- `DB_HIGH`: the level is settled high.
- `DB_FALLING`: a low level is being timed.

The named transitions are:
- start-rise: `DB_LOW` to `DB_RISING`, when the raw input is sampled high.
- abort-rise: `DB_RISING` to `DB_LOW`, when a low sample arrives before the timer expires.
- accept-high: `DB_RISING` to `DB_HIGH`, when the timer expires.
- start-fall: `DB_HIGH` to `DB_FALLING`, when the raw input is sampled low.
- abort-fall: `DB_FALLING` to `DB_HIGH`, when a high sample arrives before the timer expires.
- accept-low: `DB_FALLING` to `DB_LOW`, when the timer expires.

The debounced output is high in `DB_HIGH` and in `DB_FALLING`.

The counter is a synchronous 4-bit counter with two count-enable inputs, and both must be high for it to advance. Its carry flag is high when the count is 9 and the carry-side enable is high. At 9, an enabled step applies the synchronous clear, so the count returns to 0. Inside this block the carry-side enable is tied high and the other enable takes the one-clock pulse.

Top module: `btn_press_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count and all debouncer and synchronizer state are cleared. After reset, `count` = 0 and `carry` = 0.
- R2: A single press increments `count` exactly once, however many clock cycles the button is held.
- R3: The raw input is first sampled high at edge E0 and then held. `count` still shows its old value after edge E(DB_CYCLES+2) and shows the new value after edge E(DB_CYCLES+3).
- R4: A raw level that lasts DB_CYCLES samples or fewer is ignored. A short high pulse does not count, and a short low dropout during a held press does not cause a second count.
- R5: `count` follows 0,1,...,9 and then 0. It never shows a value above 9.
- R6: `carry` is 1 exactly when `count` is 9.
- R7: Releasing the button never changes `count`. Only the press (rising) edge counts.
- R8: The counter advances only on a clock where both of its count enables are high. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw button level, high while pressed |
| count | output | CNT_W (4) | BCD press count 0..9 |
| carry | output | 1 | High when the count is 9 |

## Verification
The embedded assertions check several rules on every clock:
- the debounced level rises only after a high raw sample;
- the enable pulse never lasts two cycles;
- the count stays at or below 9 and wraps from 9 to 0 when enabled;
- the counter holds whenever either enable is low.

Other behaviour shows only across whole scenarios, so the directed bench tasks cover it. This includes the exact latency from press to count, the rejection of short glitches and dropouts, the single increment over a long hold, and a release that never counts.

// File: rtl/btn_cnt_pkg.sv
package btn_cnt_pkg;

    typedef enum logic [1:0] {
        DB_LOW     = 2'd0,
        DB_RISING  = 2'd1,
        DB_HIGH    = 2'd2,
        DB_FALLING = 2'd3
    } db_state_t;

endpackage

// File: rtl/btn_debounce.sv
module btn_debounce
    import btn_cnt_pkg::*;
#(
    parameter int DB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = (DB_CYCLES > 2) ? $clog2(DB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DB_CYCLES - 1);

    db_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DB_LOW: begin
                if (raw) begin
                    state_d = DB_RISING;
                    cnt_d   = '0;
                end
            end
            DB_RISING: begin
                if (!raw) begin
                    state_d = DB_LOW;
                end else if (cnt_q == LAST) begin
                    state_d = DB_HIGH;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DB_HIGH: begin
                if (!raw) begin
                    state_d = DB_FALLING;
                    cnt_d   = '0;
                end
            end
            DB_FALLING: begin
                if (raw) begin
                    state_d = DB_HIGH;
                end else if (cnt_q == LAST) begin
                    state_d = DB_LOW;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = DB_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DB_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            DB_HIGH, DB_FALLING: clean = 1'b1;
            default:             clean = 1'b0;
        endcase
    end

    // R4
    db_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clean) |-> $past(raw));

    // R4
    db_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(clean) |-> !$past(raw));

endmodule

// File: rtl/btn_edge_sync.sv
module btn_edge_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic pulse
);
    logic [STAGES-1:0] sr;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sr[0] <= 1'b0;
                else     sr[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sr[i] <= 1'b0;
                else     sr[i] <= sr[i-1];
            end
        end
    end

    assign pulse = sr[STAGES-2] & ~sr[STAGES-1];

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R7
    pulse_level_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(din));

endmodule

// File: rtl/decade_core.sv
module decade_core #(
    parameter int W   = 4,
    parameter int MOD = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enp,
    input  logic         ent,
    output logic [W-1:0] q,
    output logic         tc
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic step;
    logic at_last;

    assign step    = enp & ent;
    assign at_last = (q == LAST);

    always_ff @(posedge clk) begin
        if (rst)               q <= '0;
        else if (step) begin
            if (at_last)       q <= '0;
            else               q <= q + 1'b1;
        end
    end

    assign tc = ent & at_last;

    // R5
    range_chk: assert property (@(posedge clk) disable iff (rst)
        q <= LAST);

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (at_last && enp && ent) |=> (q == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(enp && ent) |=> $stable(q));

endmodule

// File: rtl/btn_press_counter.sv
module btn_press_counter #(
    parameter int DB_CYCLES   = 16,
    parameter int SYNC_STAGES = 3,
    parameter int CNT_W       = 4,
    parameter int CNT_MOD     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             btn_raw,
    output logic [CNT_W-1:0] count,
    output logic             carry
);
    logic btn_clean;
    logic press_pulse;

    btn_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
        .clk   (clk),
        .rst   (rst),
        .raw   (btn_raw),
        .clean (btn_clean)
    );

    btn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (btn_clean),
        .pulse (press_pulse)
    );

    decade_core #(.W(CNT_W), .MOD(CNT_MOD)) u_cnt (
        .clk (clk),
        .rst (rst),
        .enp (press_pulse),
        .ent (1'b1),
        .q   (count),
        .tc  (carry)
    );

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !press_pulse |=> $stable(count));

endmodule

// File: tb/tb_btn_press_counter.sv
module tb_btn_press_counter;
    localparam int CLK_PERIOD = 10;
    localparam int DB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_raw = 1'b0;
    logic [3:0] count;
    logic       carry;

    int total = 0;
    int bad = 0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_press_counter #(.DB_CYCLES(DB)) dut (
        .clk     (clk),
        .rst     (rst),
        .btn_raw (btn_raw),
        .count   (count),
        .carry   (carry)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic chk_count(input string req);
        chk(count == 4'(exp_cnt), req, int'(count), exp_cnt);
        chk(carry == (exp_cnt == 9), {req, "/R6 carry"}, int'(carry), int'(exp_cnt == 9));
    endtask

    task automatic press(input int hold);
        @(negedge clk) btn_raw = 1'b1;
        repeat (hold) @(negedge clk);
        btn_raw = 1'b0;
        repeat (DB + 8) @(negedge clk);
        exp_cnt = (exp_cnt + 1) % 10;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_cnt = 0;
        chk_count("R1 reset");
    endtask

    task automatic t_latency();
        int old;
        old = exp_cnt;
        @(negedge clk) btn_raw = 1'b1;
        repeat (DB + 3) @(negedge clk);
        chk(count == 4'(old), "R3 before", int'(count), old);
        @(negedge clk);
        exp_cnt = (old + 1) % 10;
        chk(count == 4'(exp_cnt), "R3 after", int'(count), exp_cnt);
        repeat (10) @(negedge clk);
        btn_raw = 1'b0;
        repeat (DB + 8) @(negedge clk);
        chk_count("R7 release after latency press");
    endtask

    task automatic t_long_hold();
        @(negedge clk) btn_raw = 1'b1;
        repeat (DB + 10) @(negedge clk);
        exp_cnt = (exp_cnt + 1) % 10;
        chk_count("R2 mid hold");
        repeat (300) @(negedge clk);
        chk_count("R2 long hold");
        btn_raw = 1'b0;
        repeat (DB + 8) @(negedge clk);
        chk_count("R7 release");
    endtask

    task automatic t_glitch_high();
        @(negedge clk) btn_raw = 1'b1;
        repeat (DB) @(negedge clk);
        btn_raw = 1'b0;
        repeat (DB + 8) @(negedge clk);
        chk_count("R4 short high ignored");
    endtask

    task automatic t_dropout();
        @(negedge clk) btn_raw = 1'b1;
        repeat (DB + 10) @(negedge clk);
        btn_raw = 1'b0;
        repeat (DB) @(negedge clk);
        btn_raw = 1'b1;
        repeat (DB + 10) @(negedge clk);
        btn_raw = 1'b0;
        repeat (DB + 8) @(negedge clk);
        exp_cnt = (exp_cnt + 1) % 10;
        chk_count("R4 dropout single count");
    endtask

    task automatic t_bounce();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) btn_raw = 1'b1;
            repeat (3) @(negedge clk);
            btn_raw = 1'b0;
            repeat (2) @(negedge clk);
        end
        btn_raw = 1'b1;
        repeat (DB + 12) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            btn_raw = 1'b0;
            repeat (2) @(negedge clk);
            btn_raw = 1'b1;
            repeat (3) @(negedge clk);
        end
        btn_raw = 1'b0;
        repeat (DB + 8) @(negedge clk);
        exp_cnt = (exp_cnt + 1) % 10;
        chk_count("R2 bounced press single count");
    endtask

    task automatic t_wrap();
        while (exp_cnt != 9) begin
            press(DB + 4);
            chk_count("R5 step");
        end
        chk(carry == 1'b1, "R6 carry at 9", int'(carry), 1);
        press(DB + 4);
        chk(count == 4'd0, "R5 wrap to 0", int'(count), 0);
        chk(carry == 1'b0, "R6 carry after wrap", int'(carry), 0);
    endtask

    task automatic t_mid_reset();
        press(DB + 4);
        press(DB + 4);
        chk_count("R8 counts before reset");
        t_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_long_hold();
        t_glitch_high();
        t_dropout();
        t_bounce();
        t_wrap();
        t_mid_reset();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule